// File: doc/BRIEF.md
# Input Change Interrupt Release Logic

This block raises an active-low interrupt request when any unmasked input pin differs from the value the host last read for it. The 40 inputs are arranged as five banks of eight bits. Each bank keeps its own copy of the last value returned to the host. A per-bit mask, where 1 means suppressed, keeps chosen pins from ever requesting service.

The register access logic pulses a read strobe together with a bank index each time the host reads an input bank. That read copies the live pins into the bank's copy, so the bank's pending changes clear at the same clock edge. The request therefore stays asserted through a partial read sequence. It lets go only once no bank holds an unread change. In a normal sequence that starts at bank 0 and counts upward, this happens at the read of the highest-numbered bank that held a change. A pin that returns to its last-read level before the host reads it stops counting as a change.

Top module: `input_change_irq`

## Requirements
- R1: While reset is low and at the first edge after it, irq_n_o is 1. Every bank's copy is loaded from the pins during reset, so no change is pending when reset ends.
- R2: If any pin differs from its bank copy and its mask bit is 0, irq_n_o is 0 after the next rising edge.
- R3: A pin whose mask bit is 1 never drives irq_n_o low, whatever its value.
- R4: A read (rd_stb_i=1, rd_bank_i=b with b < 5) loads bank b's copy from pins[8b+7:8b] at that edge and clears bank b's pending changes. The copies of the other banks are unchanged.
- R5: While changes are pending in several banks, a read of any bank below the highest changed bank leaves irq_n_o at 0.
- R6: In an ascending read sequence starting at bank 0, irq_n_o returns to 1 at the edge of the read of the highest changed bank, and not earlier.
- R7: A pin that returns to its copy value before being read removes its change. If no other change is pending, irq_n_o returns to 1 at the next edge.
- R8: A read with rd_bank_i of 5, 6 or 7 does nothing: no copy changes and irq_n_o keeps its value.
- R9: Setting the mask bit of a pending change releases irq_n_o when nothing else is pending. Clearing the mask bit of a pin that still differs from its copy asserts irq_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. The copies load from the pins while it is low |
| pins_i | input | 40 | Synchronized input pins. Bank b is bits 8b+7:8b |
| mask_i | input | 40 | Per-pin interrupt mask. 1 means suppressed |
| rd_stb_i | input | 1 | One-cycle pulse for a host read of an input bank |
| rd_bank_i | input | 3 | Index of the bank being read |
| irq_n_o | output | 1 | Interrupt request, active low. 1 means released |

## Verification
The assertions assume that the pins and the mask have already been synchronized, so they hold steady across each rising edge. They also assume that rd_bank_i matters only while rd_stb_i is high, and that reset is held for at least one edge so the copies are loaded. The stimulus keeps within these limits. It changes pins, mask and the read request only on the falling clock edge, and it holds reset for several edges. Each check compares the interrupt line with a bench model that keeps its own per-bank copies.

// File: rtl/ic_irq_pkg.sv
package ic_irq_pkg;

  // Highest set position among the low n bits of v; 0 when none is set.
  function automatic int unsigned highest_set(input logic [31:0] v, input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && v[i]) idx = i;
    end
    return idx;
  endfunction

  // True when a bank index names an existing bank.
  function automatic logic index_in_range(input int unsigned idx, input int unsigned n);
    return idx < n;
  endfunction

endpackage

// File: rtl/ic_read_decode.sv
module ic_read_decode #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                 rd_stb_i,
  input  logic [IDX_W-1:0]     rd_bank_i,
  output logic [NUM_BANKS-1:0] hit_o,
  output logic                 valid_o
);
  import ic_irq_pkg::*;

  assign valid_o = rd_stb_i && index_in_range(int'(rd_bank_i), NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    localparam logic [IDX_W-1:0] BANK_ID = IDX_W'(b);
    assign hit_o[b] = rd_stb_i && (rd_bank_i == BANK_ID);
  end

endmodule

// File: rtl/ic_bank_tracker.sv
module ic_bank_tracker #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] live_i,
  input  logic [BANK_W-1:0] mask_i,
  input  logic              rd_hit_i,
  output logic              evt_now_o,
  output logic              evt_nxt_o
);

  // Unmasked bits whose live value departs from the last-read copy.
  function automatic logic [BANK_W-1:0] pending_bits(
    input logic [BANK_W-1:0] live,
    input logic [BANK_W-1:0] seen,
    input logic [BANK_W-1:0] mask
  );
    return (live ^ seen) & ~mask;
  endfunction

  logic [BANK_W-1:0] seen_q;
  logic [BANK_W-1:0] seen_nxt;

  assign seen_nxt = rd_hit_i ? live_i : seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || rd_hit_i) seen_q <= live_i;
  end

  assign evt_now_o = |pending_bits(live_i, seen_q, mask_i);
  assign evt_nxt_o = |pending_bits(live_i, seen_nxt, mask_i);

endmodule

// File: rtl/ic_top_bank.sv
module ic_top_bank #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_BANKS-1:0] flags_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  import ic_irq_pkg::*;

  logic [31:0] flags_wide;

  assign flags_wide = 32'(flags_i);
  assign any_o      = |flags_i;
  assign idx_o      = IDX_W'(highest_set(flags_wide, NUM_BANKS));

endmodule

// File: rtl/input_change_irq.sv
module input_change_irq #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned BANK_W    = 8,
  localparam int unsigned PIN_W    = NUM_BANKS * BANK_W,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pins_i,
  input  logic [PIN_W-1:0] mask_i,
  input  logic             rd_stb_i,
  input  logic [IDX_W-1:0] rd_bank_i,
  output logic             irq_n_o
);

  // Named internal events, observed by the bound checker.
  logic [NUM_BANKS-1:0] rd_hit;
  logic                 rd_valid;
  logic [NUM_BANKS-1:0] bank_evt_now;
  logic [NUM_BANKS-1:0] bank_evt_nxt;
  logic                 top_any;
  logic [IDX_W-1:0]     top_idx;
  logic                 rd_below_top;
  logic                 irq_q;

  ic_read_decode #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
  ) u_decode (
    .rd_stb_i  (rd_stb_i),
    .rd_bank_i (rd_bank_i),
    .hit_o     (rd_hit),
    .valid_o   (rd_valid)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ic_bank_tracker #(
      .BANK_W (BANK_W)
    ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .live_i    (pins_i[b*BANK_W +: BANK_W]),
      .mask_i    (mask_i[b*BANK_W +: BANK_W]),
      .rd_hit_i  (rd_hit[b]),
      .evt_now_o (bank_evt_now[b]),
      .evt_nxt_o (bank_evt_nxt[b])
    );
  end

  ic_top_bank #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W)
  ) u_top (
    .flags_i (bank_evt_now),
    .any_o   (top_any),
    .idx_o   (top_idx)
  );

  assign rd_below_top = rd_valid && top_any && (rd_bank_i < top_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |bank_evt_nxt;
  end

  assign irq_n_o = ~irq_q;

endmodule

// File: rtl/ic_irq_chk.sv
module ic_irq_chk #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_n,
  input logic                 rd_stb,
  input logic                 rd_valid,
  input logic [NUM_BANKS-1:0] rd_hit,
  input logic [NUM_BANKS-1:0] evt_now,
  input logic [NUM_BANKS-1:0] evt_nxt,
  input logic                 rd_below_top
);

  // R2
  unread_change_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_now & ~rd_hit) != '0) |=> !irq_n);

  // R3
  quiet_stays_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_now == '0) |=> irq_n);

  // R4
  read_clears_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((evt_nxt & rd_hit) == '0));

  // R5
  partial_read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_below_top |=> !irq_n);

  // R8
  bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_valid && (evt_now != '0)) |=> !irq_n);

  // R8
  bad_index_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_valid) |-> (rd_hit == '0));

endmodule

bind input_change_irq ic_irq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .IDX_W     (IDX_W)
) u_irq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_n        (irq_n_o),
  .rd_stb       (rd_stb_i),
  .rd_valid     (rd_valid),
  .rd_hit       (rd_hit),
  .evt_now      (bank_evt_now),
  .evt_nxt      (bank_evt_nxt),
  .rd_below_top (rd_below_top)
);

// File: tb/test_input_change_irq.sv
module test_input_change_irq;
  localparam int CLK_P = 10;
  localparam int NB    = 5;
  localparam int BW    = 8;

  typedef struct {
    logic  exp_irq_n;
    string tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [39:0]   pins = 40'h5A_C3_0F_96_21;
  logic [39:0]   mask = '0;
  logic          rd_stb = 1'b0;
  logic [2:0]    rd_bank = '0;
  logic          irq_n;

  int            n_run = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;
  logic [39:0]   copy_m;
  sb_item_t      sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  input_change_irq i_input_change_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins),
    .mask_i    (mask),
    .rd_stb_i  (rd_stb),
    .rd_bank_i (rd_bank),
    .irq_n_o   (irq_n)
  );

  // Bench model: apply this cycle's read, then report the expected line level.
  function automatic logic model_step();
    if (rd_stb && rd_bank < 3'(NB))
      copy_m[rd_bank*BW +: BW] = pins[rd_bank*BW +: BW];
    return ((pins ^ copy_m) & ~mask) == '0;
  endfunction

  // Driver: called at a falling edge with inputs already set; pushes the expectation.
  task automatic step(input string tag);
    sb_item_t it;
    it.exp_irq_n = model_step();
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic do_read(input int b, input string tag);
    rd_stb = 1'b1;
    rd_bank = 3'(b);
    step(tag);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_run++;
        if (irq_n !== it.exp_irq_n) begin
          n_fail++;
          $display("FAIL %s: irq_n_o=%b expected %b", it.tag, irq_n, it.exp_irq_n);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2B57;
    repeat (3) @(negedge clk);
    n_run++;
    if (irq_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: irq_n_o=%b during reset expected 1", irq_n);
    end
    copy_m = pins;
    rst_n = 1'b1;
    step("R1 idle after reset");
    step("R1 still idle");

    // R2 / R4: single change, then read that bank.
    pins[1*8+3] = ~pins[1*8+3];
    step("R2 bank1 bit3 change");
    do_read(1, "R4 read bank1 releases");

    // R3 / R9: masked pin.
    mask[0] = 1'b1;
    pins[0] = ~pins[0];
    step("R3 masked change ignored");
    step("R3 masked change still ignored");
    mask[0] = 1'b0;
    step("R9 unmask stale difference asserts");
    mask[0] = 1'b1;
    step("R9 re-mask releases");
    do_read(0, "R4 read bank0");
    mask[0] = 1'b0;
    step("R9 unmask after read stays released");

    // R5 / R6: changes in banks 2 and 4, ascending sequence.
    pins[2*8+4] = ~pins[2*8+4];
    pins[4*8+7] = ~pins[4*8+7];
    step("R2 two-bank change");
    do_read(0, "R5 read bank0 holds");
    do_read(1, "R5 read bank1 holds");
    do_read(2, "R5 read bank2 holds");
    do_read(3, "R6 read bank3 holds");
    do_read(4, "R6 read bank4 releases");

    // R5: reverse order, lower bank still pending.
    pins[2*8+0] = ~pins[2*8+0];
    pins[4*8+1] = ~pins[4*8+1];
    step("R2 two-bank change again");
    do_read(4, "R4 read bank4 leaves bank2 pending");
    do_read(2, "R4 read bank2 releases");

    // R7: change then revert before read.
    pins[3*8+2] = ~pins[3*8+2];
    step("R7 bank3 change");
    pins[3*8+2] = ~pins[3*8+2];
    step("R7 revert releases");

    // R8: out-of-range read index.
    pins[1*8+0] = ~pins[1*8+0];
    step("R8 change before bad read");
    do_read(5, "R8 index5 ignored");
    do_read(7, "R8 index7 ignored");
    do_read(1, "R8 real read releases");

    // R4: read of an unrelated bank leaves the change pending.
    pins[3*8+6] = ~pins[3*8+6];
    do_read(0, "R4 unrelated read holds");
    do_read(3, "R4 owning read releases");

    // Mixed pseudo-random traffic.
    for (int k = 0; k < 120; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[3:0] < 4'd6) pins[lfsr[15:8] % 40] = ~pins[lfsr[15:8] % 40];
      if (lfsr[7:4] == 4'd0) mask[lfsr[23:16] % 40] = ~mask[lfsr[23:16] % 40];
      if (lfsr[27]) begin
        rd_stb = 1'b1;
        rd_bank = lfsr[30:28];
      end
      step("R2 mixed traffic");
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule